// File: doc/BRIEF.md
# Parallel Trinomial Additive Scrambler

This block whitens a data stream 16 bits per clock by XORing each input word with a pseudo-random keystream. The keystream is the output of a linear recurrence defined by a trinomial x^N + x^K + 1. N and K are fixed at elaboration. The scrambling is additive, so the keystream does not depend on the data. The same block therefore also descrambles: a receiver loaded with the same seed and fed the scrambled words gets the original words back.

A naive 16-way unrolling of the recurrence chains several XOR gates between registers. This design instead applies the recurrence to a folded polynomial, the original trinomial raised to a power of two. That polynomial is still a trinomial, with lags long enough that all 16 new keystream bits depend only on bits already held in registers. Every register's next value is then a plain copy of another register or the XOR of exactly two registers. The stored history is just long enough for the longer folded lag.

A seed strobe places an N-bit seed in the keystream positions just before the next output word. A word is consumed only when its valid strobe is high. The scrambled word appears, registered, one cycle later.

Top module: `trs_scrambler`

## Requirements
- R1: For any trinomial x^N + x^K + 1 with N > K >= 1, the keystream obeys s[t] = s[t-N] XOR s[t-K], matching a serial bit-by-bit model.
- R2: Each accepted word consumes 16 consecutive keystream bits. Output bit i = input bit i XOR s[n+i], where bit 0 is the earliest position in serial order.
- R3: When din_vld is high and seed_ld is low at a rising edge, dout_vld is high for the following cycle. Otherwise dout_vld is low for the following cycle.
- R4: A seed load sets s[n-N+j] = seed[j] for j = 0..N-1, where n is the first keystream position used by the next accepted word. Seed bit N-1 is therefore the most recent position.
- R5: A cycle with din_vld low and seed_ld low leaves the keystream position unchanged, holds dout, and gives dout_vld low on the next cycle.
- R6: seed_ld takes priority. A word presented in the same cycle as a load is discarded: dout keeps its value and dout_vld is low on the next cycle.
- R7: An all-zero seed is accepted and yields an all-zero keystream, so dout equals din.
- R8: A second instance loaded with the same seed and fed the scrambled words returns the original words.
- R9: While rst_n is low, dout and dout_vld are zero. After reset the keystream state is all zero, so the first words pass through unchanged until a seed is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 16 | Data word; bit 0 is earliest in serial order |
| din_vld | input | 1 | Marks din as a word to be scrambled |
| seed_ld | input | 1 | Loads seed into the keystream history |
| seed | input | N | Seed value; bit N-1 is the most recent keystream position |
| dout | output | 16 | Scrambled word |
| dout_vld | output | 1 | High for one cycle per accepted word |

## Verification
A word or seed presented before a rising edge produces its effect on dout and dout_vld right after that edge, one register stage later. After rst_n rises, the internal reset stays asserted for two more edges. The bench therefore idles three cycles before its first word.

Inputs change on the falling edge. Each result is sampled on the next falling edge, so every sample falls exactly one register stage after the stimulus it checks. Expected words come from a serial shift-register model that advances 16 bits only when a word is accepted. The model runs alongside three polynomials whose fold factors are 1, 4 and 16.

// File: rtl/trs_pkg.sv
package trs_pkg;

  // Smallest power of two f such that f*k reaches the word width w.
  // The folded short lag f*k then covers every bit of one output word.
  function automatic int unsigned fold_factor(input int unsigned k, input int unsigned w);
    int unsigned f;
    f = 1;
    for (int i = 0; i < 32; i++) begin
      if (f * k < w) f = f * 2;
    end
    return f;
  endfunction

endpackage

// File: rtl/trs_seed_expand.sv
// Turns an N-bit seed into the full folded-state image. It extends the
// sequence backwards and forwards with the base recurrence. This logic
// sits on the path from the seed pins only.
module trs_seed_expand #(
  parameter int unsigned POLY_N  = 7,
  parameter int unsigned POLY_K  = 4,
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned STATE_W = 28
) (
  input  logic [POLY_N-1:0]  seed_i,
  output logic [STATE_W-1:0] image_o
);

  localparam int unsigned TAIL_W = STATE_W - WORD_W;
  localparam int unsigned BACK_W = (POLY_N > TAIL_W) ? POLY_N : TAIL_W;
  localparam int unsigned SPAN_W = BACK_W + WORD_W;
  localparam int unsigned BASE   = BACK_W - TAIL_W;

  function automatic logic [STATE_W-1:0] spread(input logic [POLY_N-1:0] s);
    logic [SPAN_W-1:0] t;
    t = '0;
    for (int i = 0; i < int'(POLY_N); i++) begin
      t[BACK_W-POLY_N+i] = s[i];
    end
    for (int i = int'(BACK_W) - int'(POLY_N) - 1; i >= 0; i--) begin
      t[i] = t[i+POLY_N] ^ t[i+POLY_N-POLY_K];
    end
    for (int i = int'(BACK_W); i < int'(SPAN_W); i++) begin
      t[i] = t[i-POLY_N] ^ t[i-POLY_K];
    end
    return t[BASE +: STATE_W];
  endfunction

  assign image_o = spread(seed_i);

endmodule

// File: rtl/trs_state.sv
// Folded keystream state. state_q[q] holds s[n-STATE_W+WORD_W+q]. The top
// WORD_W bits are the keystream for the next word.
module trs_state #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned STATE_W = 28,
  parameter int unsigned LAG_S   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [STATE_W-1:0] image_i,
  input  logic               adv_i,
  output logic [WORD_W-1:0]  ks_o
);

  localparam int unsigned TAIL_W = STATE_W - WORD_W;
  localparam int unsigned TAP_OF = STATE_W - LAG_S;

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic [STATE_W-1:0] stepped;

  for (genvar q = 0; q < STATE_W; q++) begin : g_step
    if (q < TAIL_W) begin : g_copy
      assign stepped[q] = state_q[q+WORD_W];
    end else begin : g_new
      assign stepped[q] = state_q[q-TAIL_W] ^ state_q[q-TAIL_W+TAP_OF];
    end
  end

  always_comb begin
    state_d = state_q;
    if (load_i) begin
      state_d = image_i;
    end else if (adv_i) begin
      state_d = stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else begin
      state_q <= state_d;
    end
  end

  assign ks_o = state_q[STATE_W-1 -: WORD_W];

  // R5
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(state_q));

  // R7
  zero_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == '0 && !load_i) |=> (state_q == '0));

endmodule

// File: rtl/trs_outreg.sv
module trs_outreg #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic [WORD_W-1:0] ks_i,
  output logic [WORD_W-1:0] dout_o,
  output logic              dvld_o
);

  logic [WORD_W-1:0] dout_q, dout_d;
  logic              dvld_q, dvld_d;

  always_comb begin
    dout_d = dout_q;
    dvld_d = take_i;
    if (take_i) dout_d = din_i ^ ks_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dvld_q <= 1'b0;
    end else begin
      dout_q <= dout_d;
      dvld_q <= dvld_d;
    end
  end

  assign dout_o = dout_q;
  assign dvld_o = dvld_q;

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(dout_o));

endmodule

// File: rtl/trs_scrambler.sv
module trs_scrambler #(
  parameter int unsigned POLY_N = 7,
  parameter int unsigned POLY_K = 4,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] din,
  input  logic              din_vld,
  input  logic              seed_ld,
  input  logic [POLY_N-1:0] seed,
  output logic [WORD_W-1:0] dout,
  output logic              dout_vld
);

  localparam int unsigned FOLD    = trs_pkg::fold_factor(POLY_K, WORD_W);
  localparam int unsigned STATE_W = FOLD * POLY_N;
  localparam int unsigned LAG_S   = FOLD * POLY_K;

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic               adv;
  logic [STATE_W-1:0] image;
  logic [WORD_W-1:0]  ks;

  assign adv = din_vld & ~seed_ld;

  trs_seed_expand #(
    .POLY_N (POLY_N),
    .POLY_K (POLY_K),
    .WORD_W (WORD_W),
    .STATE_W(STATE_W)
  ) expand_i (
    .seed_i (seed),
    .image_o(image)
  );

  trs_state #(
    .WORD_W (WORD_W),
    .STATE_W(STATE_W),
    .LAG_S  (LAG_S)
  ) state_i (
    .clk    (clk),
    .rst_n  (rst_sync),
    .load_i (seed_ld),
    .image_i(image),
    .adv_i  (adv),
    .ks_o   (ks)
  );

  trs_outreg #(
    .WORD_W(WORD_W)
  ) out_i (
    .clk   (clk),
    .rst_n (rst_sync),
    .take_i(adv),
    .din_i (din),
    .ks_i  (ks),
    .dout_o(dout),
    .dvld_o(dout_vld)
  );

  // R3
  word_vld_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (din_vld && !seed_ld) |=> dout_vld);

  // R6
  load_drop_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    seed_ld |=> (!dout_vld && $stable(dout)));

endmodule

// File: tb/trs_scrambler_tb_top.sv
`timescale 1ns/1ps
module trs_scrambler_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [15:0] din;
  logic        din_vld;
  logic        seed_ld;
  logic [23:0] seed_v;
  logic [15:0] dq [3];
  logic        vq [3];

  trs_scrambler #(.POLY_N(7), .POLY_K(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld), .seed_ld(seed_ld),
    .seed(seed_v[6:0]), .dout(dq[0]), .dout_vld(vq[0]));
  trs_scrambler #(.POLY_N(23), .POLY_K(18)) dut_b (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld), .seed_ld(seed_ld),
    .seed(seed_v[22:0]), .dout(dq[1]), .dout_vld(vq[1]));
  trs_scrambler #(.POLY_N(9), .POLY_K(1)) dut_c (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld), .seed_ld(seed_ld),
    .seed(seed_v[8:0]), .dout(dq[2]), .dout_vld(vq[2]));

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;
  int          pn [3] = '{7, 23, 9};
  int          pk [3] = '{4, 18, 1};
  logic [63:0] rr [3];
  logic [15:0] ex [3];
  bit          kz [3];
  bit          after_ld;

  // {seed_ld, seed[23:0], din_vld, din[15:0]}
  localparam logic [41:0] STIM [18] = '{
    {1'b1, 24'h5A5A35, 1'b0, 16'h0000},
    {1'b0, 24'h000000, 1'b1, 16'h0000},
    {1'b0, 24'h000000, 1'b1, 16'hFFFF},
    {1'b0, 24'h000000, 1'b1, 16'h1234},
    {1'b0, 24'h000000, 1'b0, 16'h9999},
    {1'b0, 24'h000000, 1'b1, 16'hABCD},
    {1'b1, 24'h000000, 1'b1, 16'h7777},
    {1'b0, 24'h000000, 1'b1, 16'h1357},
    {1'b0, 24'h000000, 1'b1, 16'h0000},
    {1'b1, 24'h000001, 1'b0, 16'h0000},
    {1'b0, 24'h000000, 1'b1, 16'h0F0F},
    {1'b0, 24'h000000, 1'b0, 16'h0000},
    {1'b0, 24'h000000, 1'b0, 16'h5555},
    {1'b0, 24'h000000, 1'b1, 16'hF00D},
    {1'b1, 24'hFFFFFF, 1'b1, 16'h4444},
    {1'b0, 24'h000000, 1'b1, 16'h8001},
    {1'b0, 24'h000000, 1'b1, 16'h3C3C},
    {1'b0, 24'h000000, 1'b1, 16'hC0DE}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic ref_load(input int u, input logic [23:0] sd);
    rr[u] = '0;
    for (int i = 0; i < pn[u]; i++) rr[u][pn[u]-1-i] = sd[i];
  endtask

  task automatic ref_word(input int u, output logic [15:0] ks);
    for (int i = 0; i < 16; i++) begin
      logic b;
      b = rr[u][pn[u]-1] ^ rr[u][pk[u]-1];
      ks[i] = b;
      rr[u] = {rr[u][62:0], b};
    end
  endtask

  task automatic step(input logic ld, input logic [23:0] sd, input logic v,
                      input logic [15:0] d, input string note);
    logic [15:0] ks;
    logic        ev;
    string       tag;
    string       vtag;
    bit          was_after;
    seed_ld = ld; seed_v = sd; din_vld = v; din = d;
    ev = v && !ld;
    was_after = after_ld;
    for (int u = 0; u < 3; u++) begin
      if (ld) ref_load(u, sd);
      else if (v) begin
        ref_word(u, ks);
        ex[u] = d ^ ks;
        kz[u] = (ks == 16'h0000);
      end
    end
    if (ld) after_ld = 1;
    else if (v) after_ld = 0;
    @(posedge clk);
    @(negedge clk);
    seed_ld = 1'b0; din_vld = 1'b0;
    for (int u = 0; u < 3; u++) begin
      if (note != "") tag = note;
      else if (ld) tag = v ? "R6 dropped word" : "R4 load holds output";
      else if (!v) tag = "R5 stall";
      else if (kz[u]) tag = "R7 zero keystream";
      else if (was_after) tag = "R4 first word after seed";
      else if (u == 0) tag = "R2 word vs serial model";
      else tag = "R1 other trinomial";
      vtag = ld ? "R6 valid after load" : (v ? "R3 valid follows word" : "R5 valid on stall");
      check($sformatf("%s dut%0d", tag, u), {16'h0, dq[u]}, {16'h0, ex[u]});
      check($sformatf("%s dut%0d", vtag, u), {31'h0, vq[u]}, {31'h0, ev});
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] y;
    rst_n = 1'b0; din = '0; din_vld = 1'b0; seed_ld = 1'b0; seed_v = '0;
    after_ld = 0;
    for (int u = 0; u < 3; u++) begin rr[u] = '0; ex[u] = '0; kz[u] = 0; end
    repeat (3) @(negedge clk);
    for (int u = 0; u < 3; u++) begin
      check("R9 dout in reset", {16'h0, dq[u]}, 32'h0);
      check("R9 valid in reset", {31'h0, vq[u]}, 32'h0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1'b0, 24'h0, 1'b1, 16'hBEEF, "R9 pass-through after reset");
    step(1'b0, 24'h0, 1'b0, 16'h0000, "R3 valid drops after word");

    for (int e = 0; e < 18; e++) begin
      step(STIM[e][41], STIM[e][40:17], STIM[e][16], STIM[e][15:0], "");
    end

    // R8: descramble with the same seed
    step(1'b1, 24'h3A6C91, 1'b0, 16'h0000, "R4 load for descramble");
    step(1'b0, 24'h0, 1'b1, 16'hCAFE, "R2 scramble for descramble");
    y = dq[0];
    step(1'b1, 24'h3A6C91, 1'b0, 16'h0000, "R4 reload for descramble");
    step(1'b0, 24'h0, 1'b1, y, "R8 descramble");
    check("R8 restored word", {16'h0, dq[0]}, 32'h0000CAFE);

    // R9: reset in mid-run
    rst_n = 1'b0;
    #1;
    for (int u = 0; u < 3; u++) begin
      check("R9 async clear dout", {16'h0, dq[u]}, 32'h0);
      check("R9 async clear valid", {31'h0, vq[u]}, 32'h0);
      rr[u] = '0; ex[u] = '0;
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1'b0, 24'h0, 1'b1, 16'h6A6A, "R9 zero state after reset");

    done = 1;
    summary();
    $finish;
  end

endmodule